// File: doc/BRIEF.md
# Controlled reversible ALU

This block is a combinational arithmetic-logic unit built as an ordered network of reversible gates. It has controlled NOT, doubly controlled NOT and controlled swap gates, and every gate acts on one line vector. That vector holds five control lines, an N-bit operand A and an N-bit operand B. The control lines and A leave the block with the values they came in with. Only the B lines change, and they carry the result of a reversible update.

A single ripple adder does all the arithmetic. It is shaped as a descending carry pass followed by an ascending sum-and-uncompute pass. Five independent control lines switch groups of its gates on or off:
- one conditionally inverts B before the adder;
- one seeds the carry chain with a 1;
- one enables the per-bit A-into-B mixing;
- one enables folding the carry into each sum bit;
- one conditionally inverts the result.

The adder needs no spare line, because the carry-seed control line itself serves as the carry line and is restored before the output. A direction input selects either the forward network or the same gates in reverse order. A caller, or a check, can therefore undo any update exactly.

Top module: `rev_ctl_alu`

## Requirements
- R1: In both directions, `ctl_o` equals `ctl_i` and `a_o` equals `a_i` for every input.
- R2: The control vector is `ctl_i[4]` invert-B-in, `ctl_i[3]` carry seed, `ctl_i[2]` mix enable, `ctl_i[1]` carry fold, `ctl_i[0]` invert-out. With `dir_i`=0 and `ctl_i`=5'b00110, `b_o` = (B + A) mod 2^N.
- R3: With `dir_i`=0 and `ctl_i`=5'b10111, `b_o` = (B − A) mod 2^N.
- R4: With `dir_i`=0 and `ctl_i`=5'b11110, `b_o` = (A − B) mod 2^N. With A = 0 this is the two's complement negation of B.
- R5: With `dir_i`=0 and `ctl_i`=5'b00100, `b_o` = B XOR A.
- R6: With `dir_i`=0 and `ctl_i`=5'b00000, `b_o` = B.
- R7: With `dir_i`=0 and `ctl_i`=5'b01110, `b_o` = (B + A + 1) mod 2^N.
- R8: For all 32 control codes, two steps return the original B: forward then reverse (`dir_i`=1), and reverse then forward. The control lines and A are fed back unchanged in each case.
- R9: Applying the forward 5'b11110 update twice restores B. Applying the forward 5'b10111 update after the forward 5'b00110 update restores B.
- R10: Results wrap modulo 2^N with no lost information. Examples: all-ones plus one gives zero under 5'b00110, and zero minus one gives all-ones under 5'b10111.
- R11: In the forward direction, 5'b11111 gives (B − A − 1) mod 2^N, 5'b10110 gives (A − B − 1) mod 2^N, and 5'b10000 gives the bitwise inverse of B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dir_i | input | 1 | 0 applies the forward gate order, 1 applies the reversed order |
| ctl_i | input | 5 | Control lines, bit layout as in R2 |
| a_i | input | N | Operand A lines |
| b_i | input | N | Operand B lines |
| ctl_o | output | 5 | Control lines after the network |
| a_o | output | N | Operand A lines after the network |
| b_o | output | N | Updated B lines |

## Verification
The hardest cases to reach from the ports are the carry chain rippling through every controlled swap, and the control codes that match none of the named operations. Both appear on the B lines only in combination with other gate groups. The stimulus uses directed operands that force the full ripple, such as all-ones plus one and zero minus one. It also sweeps all 32 control codes with random operands, feeding each forward result back through the reverse order and each reverse result through the forward order. Any misplaced swap or an uncompute left out then shows up as a B value that fails to return.

// File: rtl/rv_alu_pkg.sv
package rv_alu_pkg;

    localparam int CTL_W = 5;

    // Bit positions of the control lines inside the control vector
    localparam int CB_NEG_IN   = 4;
    localparam int CB_SEED     = 3;
    localparam int CB_MIX      = 2;
    localparam int CB_FOLD     = 1;
    localparam int CB_NEG_OUT  = 0;

    typedef struct packed {
        logic neg_in;
        logic seed;
        logic mix_en;
        logic fold;
        logic neg_out;
    } rv_ctl_t;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_REV = 1'b1
    } rv_dir_e;

    localparam logic [CTL_W-1:0] OP_ADD     = 5'b00110;
    localparam logic [CTL_W-1:0] OP_SUB     = 5'b10111;
    localparam logic [CTL_W-1:0] OP_NSUB    = 5'b11110;
    localparam logic [CTL_W-1:0] OP_XOR     = 5'b00100;
    localparam logic [CTL_W-1:0] OP_NOP     = 5'b00000;
    localparam logic [CTL_W-1:0] OP_ADD_INC = 5'b01110;

endpackage

// File: rtl/rv_not_array.sv
// Row of controlled NOT gates: every data line flips when the control line is high.
module rv_not_array #(
    parameter int N = 16
) (
    input  logic         en_i,
    input  logic [N-1:0] x_i,
    output logic [N-1:0] x_o
);
    always_comb begin
        x_o = x_i ^ {N{en_i}};
    end
endmodule

// File: rtl/rv_mix_array.sv
// Row of doubly controlled NOT gates: B line i flips when enable and A line i are both high.
module rv_mix_array #(
    parameter int N = 16
) (
    input  logic         en_i,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] b_o
);
    always_comb begin
        b_o = b_i ^ ({N{en_i}} & a_i);
    end
endmodule

// File: rtl/rv_vshape.sv
// Ripple adder core built from controlled swaps (carry pass) and doubly
// controlled NOTs (carry fold). The carry-seed line and the A lines form one
// chain: position 0 is the seed line, position k+1 is A line k. Swap k
// exchanges positions k and k+1 under B line k, leaving carry k+1 at
// position k+1. REVERSE selects the mirrored gate order.
module rv_vshape #(
    parameter int N       = 16,
    parameter bit REVERSE = 1'b0
) (
    input  logic         seed_i,
    input  logic         fold_i,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic         seed_o,
    output logic [N-1:0] a_o,
    output logic [N-1:0] b_o
);
    localparam int CW = N + 1;

    function automatic logic [CW-1:0] swap_at(
        input logic [CW-1:0] ch,
        input logic [N-1:0]  ctl,
        input int            k
    );
        logic [CW-1:0] r;
        r = ch;
        if (ctl[k]) begin
            r[k]     = ch[k+1];
            r[k+1]   = ch[k];
        end
        return r;
    endfunction

    logic [CW-1:0] chain_q;
    logic [N-1:0]  sum_q;

    generate
        if (REVERSE == 1'b0) begin : g_fwd
            always_comb begin
                chain_q = {a_i, seed_i};
                sum_q   = b_i;
                // descending pass: build carries
                for (int k = 0; k < N - 1; k++) begin
                    chain_q = swap_at(chain_q, sum_q, k);
                end
                // ascending pass: fold carry into sum, then uncompute
                for (int i = N - 1; i >= 1; i--) begin
                    sum_q[i] = sum_q[i] ^ (fold_i & chain_q[i]);
                    chain_q  = swap_at(chain_q, sum_q, i - 1);
                end
                sum_q[0] = sum_q[0] ^ (fold_i & chain_q[0]);
            end
        end else begin : g_rev
            always_comb begin
                chain_q = {a_i, seed_i};
                sum_q   = b_i;
                sum_q[0] = sum_q[0] ^ (fold_i & chain_q[0]);
                for (int i = 1; i < N; i++) begin
                    chain_q  = swap_at(chain_q, sum_q, i - 1);
                    sum_q[i] = sum_q[i] ^ (fold_i & chain_q[i]);
                end
                for (int k = N - 2; k >= 0; k--) begin
                    chain_q = swap_at(chain_q, sum_q, k);
                end
            end
        end
    endgenerate

    assign seed_o = chain_q[0];
    assign a_o    = chain_q[CW-1:1];
    assign b_o    = sum_q;

endmodule

// File: rtl/rv_net.sv
// Complete gate network in one direction.
module rv_net
    import rv_alu_pkg::*;
#(
    parameter int N       = 16,
    parameter bit REVERSE = 1'b0
) (
    input  logic [CTL_W-1:0] ctl_i,
    input  logic [N-1:0]     a_i,
    input  logic [N-1:0]     b_i,
    output logic [CTL_W-1:0] ctl_o,
    output logic [N-1:0]     a_o,
    output logic [N-1:0]     b_o
);
    rv_ctl_t       ctl;
    logic          seed_out;
    logic [N-1:0]  b_s1;
    logic [N-1:0]  b_s2;
    logic [N-1:0]  b_s3;

    assign ctl = rv_ctl_t'(ctl_i);

    generate
        if (REVERSE == 1'b0) begin : g_fwd
            logic [N-1:0] a_core;
            rv_not_array #(.N(N)) u_neg_in (
                .en_i (ctl.neg_in), .x_i (b_i), .x_o (b_s1)
            );
            rv_mix_array #(.N(N)) u_mix (
                .en_i (ctl.mix_en), .a_i (a_i), .b_i (b_s1), .b_o (b_s2)
            );
            rv_vshape #(.N(N), .REVERSE(1'b0)) u_core (
                .seed_i (ctl.seed), .fold_i (ctl.fold),
                .a_i (a_i), .b_i (b_s2),
                .seed_o (seed_out), .a_o (a_core), .b_o (b_s3)
            );
            rv_not_array #(.N(N)) u_neg_out (
                .en_i (ctl.neg_out), .x_i (b_s3), .x_o (b_o)
            );
            assign a_o = a_core;
        end else begin : g_rev
            logic [N-1:0] a_core;
            rv_not_array #(.N(N)) u_neg_out (
                .en_i (ctl.neg_out), .x_i (b_i), .x_o (b_s1)
            );
            rv_vshape #(.N(N), .REVERSE(1'b1)) u_core (
                .seed_i (ctl.seed), .fold_i (ctl.fold),
                .a_i (a_i), .b_i (b_s1),
                .seed_o (seed_out), .a_o (a_core), .b_o (b_s2)
            );
            rv_mix_array #(.N(N)) u_mix (
                .en_i (ctl.mix_en), .a_i (a_core), .b_i (b_s2), .b_o (b_s3)
            );
            rv_not_array #(.N(N)) u_neg_in (
                .en_i (ctl.neg_in), .x_i (b_s3), .x_o (b_o)
            );
            assign a_o = a_core;
        end
    endgenerate

    always_comb begin
        ctl_o          = ctl_i;
        ctl_o[CB_SEED] = seed_out;
    end

endmodule

// File: rtl/rev_ctl_alu.sv
module rev_ctl_alu
    import rv_alu_pkg::*;
#(
    parameter int N = 16
) (
    input  logic             dir_i,
    input  logic [CTL_W-1:0] ctl_i,
    input  logic [N-1:0]     a_i,
    input  logic [N-1:0]     b_i,
    output logic [CTL_W-1:0] ctl_o,
    output logic [N-1:0]     a_o,
    output logic [N-1:0]     b_o
);
    rv_dir_e          dir;
    logic [CTL_W-1:0] f_ctl, r_ctl;
    logic [N-1:0]     f_a, f_b, r_a, r_b;

    assign dir = rv_dir_e'(dir_i);

    rv_net #(.N(N), .REVERSE(1'b0)) u_fwd (
        .ctl_i (ctl_i), .a_i (a_i), .b_i (b_i),
        .ctl_o (f_ctl), .a_o (f_a), .b_o (f_b)
    );

    rv_net #(.N(N), .REVERSE(1'b1)) u_rev (
        .ctl_i (ctl_i), .a_i (a_i), .b_i (b_i),
        .ctl_o (r_ctl), .a_o (r_a), .b_o (r_b)
    );

    always_comb begin
        unique case (dir)
            DIR_FWD: begin
                ctl_o = f_ctl;
                a_o   = f_a;
                b_o   = f_b;
            end
            DIR_REV: begin
                ctl_o = r_ctl;
                a_o   = r_a;
                b_o   = r_b;
            end
            default: begin
                ctl_o = f_ctl;
                a_o   = f_a;
                b_o   = f_b;
            end
        endcase
    end

    // Round-trip networks used only by the assertions below
    logic [CTL_W-1:0] fr_ctl, rf_ctl;
    logic [N-1:0]     fr_a, fr_b, rf_a, rf_b;

    rv_net #(.N(N), .REVERSE(1'b1)) u_chk_fr (
        .ctl_i (f_ctl), .a_i (f_a), .b_i (f_b),
        .ctl_o (fr_ctl), .a_o (fr_a), .b_o (fr_b)
    );

    rv_net #(.N(N), .REVERSE(1'b0)) u_chk_rf (
        .ctl_i (r_ctl), .a_i (r_a), .b_i (r_b),
        .ctl_o (rf_ctl), .a_o (rf_a), .b_o (rf_b)
    );

    always_comb begin
        if (!$isunknown({dir_i, ctl_i, a_i, b_i})) begin
            // R1
            pass_lines_chk: assert (ctl_o == ctl_i && a_o == a_i)
                else $error("control or A lines altered");
            // R8
            fwd_rev_chk: assert (fr_b == b_i && fr_a == a_i && fr_ctl == ctl_i)
                else $error("reverse does not undo forward");
            // R8
            rev_fwd_chk: assert (rf_b == b_i && rf_a == a_i && rf_ctl == ctl_i)
                else $error("forward does not undo reverse");
            if (dir == DIR_FWD) begin
                // R2
                add_res_chk: assert (ctl_i != OP_ADD || b_o == N'(b_i + a_i))
                    else $error("add result wrong");
                // R4
                nsub_res_chk: assert (ctl_i != OP_NSUB || b_o == N'(a_i - b_i))
                    else $error("negative subtract result wrong");
                // R5
                xor_res_chk: assert (ctl_i != OP_XOR || b_o == (b_i ^ a_i))
                    else $error("xor result wrong");
                // R6
                nop_res_chk: assert (ctl_i != OP_NOP || b_o == b_i)
                    else $error("idle code changed B");
            end
        end
    end

endmodule

// File: tb/rev_ctl_alu_bench.sv
module rev_ctl_alu_bench;
    localparam int N = 16;
    localparam logic [N-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         dir_i;
    logic [4:0]   ctl_i;
    logic [N-1:0] a_i, b_i;
    logic [4:0]   ctl_o;
    logic [N-1:0] a_o, b_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rev_ctl_alu #(.N(N)) u_rev_ctl_alu (
        .dir_i (dir_i), .ctl_i (ctl_i), .a_i (a_i), .b_i (b_i),
        .ctl_o (ctl_o), .a_o (a_o), .b_o (b_o)
    );

    task automatic drive(input logic d, input logic [4:0] c,
                         input logic [N-1:0] a, input logic [N-1:0] b);
        @(posedge clk);
        dir_i = d; ctl_i = c; a_i = a; b_i = b;
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] model(input logic [4:0] c,
                                           input logic [N-1:0] a,
                                           input logic [N-1:0] b);
        case (c)
            5'b00110: return N'(b + a);
            5'b10111: return N'(b - a);
            5'b11110: return N'(a - b);
            5'b00100: return b ^ a;
            5'b00000: return b;
            5'b01110: return N'(b + a + 1);
            5'b11111: return N'(b - a - 1);
            5'b10110: return N'(a - b - 1);
            5'b10000: return ~b;
            default:  return b;
        endcase
    endfunction

    task automatic op_check(input logic [4:0] c, input logic [N-1:0] a,
                            input logic [N-1:0] b, input string req);
        logic [N-1:0] e;
        e = model(c, a, b);
        drive(1'b0, c, a, b);
        check(b_o === e, req, b_o, e);
    endtask

    task automatic round_trip(input logic [4:0] c, input logic [N-1:0] a,
                              input logic [N-1:0] b);
        logic [N-1:0] y;
        drive(1'b0, c, a, b);
        y = b_o;
        // R1
        check(ctl_o === c && a_o === a, "R1", a_o, a);
        drive(1'b1, c, a, y);
        check(b_o === b, "R8 fwd-rev", b_o, b);
        drive(1'b1, c, a, b);
        y = b_o;
        check(ctl_o === c && a_o === a, "R1 rev", a_o, a);
        drive(1'b0, c, a, y);
        check(b_o === b, "R8 rev-fwd", b_o, b);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] ra, rb, y;
        void'($urandom(32'd5417));
        dir_i = 1'b0; ctl_i = '0; a_i = '0; b_i = '0;
        @(negedge clk);
        // idle start: all-zero lines stay zero (R6, R1)
        check(b_o === '0 && a_o === '0 && ctl_o === '0, "R6 start", b_o, '0);

        // directed corner cases
        op_check(5'b00110, 16'h0001, ONES, "R10 add wrap");
        op_check(5'b00110, ONES, 16'h0001, "R2 full ripple");
        op_check(5'b00110, 16'h1234, 16'h4321, "R2");
        op_check(5'b10111, 16'h0001, 16'h0000, "R10 sub wrap");
        op_check(5'b10111, 16'h0F0F, 16'h1000, "R3");
        op_check(5'b11110, 16'h0000, 16'h0001, "R4 negate");
        op_check(5'b11110, 16'h0000, 16'h8000, "R4 negate min");
        op_check(5'b11110, 16'h0100, 16'h0200, "R4");
        op_check(5'b00100, 16'hA5A5, 16'h0FF0, "R5");
        op_check(5'b00000, 16'hFFFF, 16'h5A5A, "R6");
        op_check(5'b01110, ONES, 16'h0000, "R7 wrap");
        op_check(5'b01110, 16'h0010, 16'h0020, "R7");
        op_check(5'b11111, 16'h0003, 16'h0010, "R11 sub dec");
        op_check(5'b10110, 16'h0010, 16'h0003, "R11 nsub dec");
        op_check(5'b10000, 16'h1234, 16'h00FF, "R11 invert");

        // R9: negative subtract twice, add then subtract
        for (int k = 0; k < 20; k++) begin
            ra = N'($urandom); rb = N'($urandom);
            drive(1'b0, 5'b11110, ra, rb);
            y = b_o;
            drive(1'b0, 5'b11110, ra, y);
            check(b_o === rb, "R9 nsub twice", b_o, rb);
            drive(1'b0, 5'b00110, ra, rb);
            y = b_o;
            drive(1'b0, 5'b10111, ra, y);
            check(b_o === rb, "R9 sub after add", b_o, rb);
        end

        // random operands on the named codes
        for (int k = 0; k < 200; k++) begin
            logic [4:0] c;
            case ($urandom % 9)
                0: c = 5'b00110; 1: c = 5'b10111; 2: c = 5'b11110;
                3: c = 5'b00100; 4: c = 5'b00000; 5: c = 5'b01110;
                6: c = 5'b11111; 7: c = 5'b10110; default: c = 5'b10000;
            endcase
            op_check(c, N'($urandom), N'($urandom), "R2-R7 R11 random");
        end

        // R8: every control code, directed and random operands
        for (int c = 0; c < 32; c++) begin
            round_trip(5'(c), ONES, 16'h0001);
            round_trip(5'(c), 16'h0000, ONES);
            for (int k = 0; k < 8; k++) begin
                round_trip(5'(c), N'($urandom), N'($urandom));
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule